// File: doc/BRIEF.md
# Dense Space Packet Builder

This block turns one 32-byte processor access into a packet for the downstream I/O path. A write arrives with a 32-byte aligned address, the full 32-byte data block and eight mask bits, one for each 4-byte slice. The block captures the access and expands the mask into 32 per-byte enables. It then sends a header beat followed by the data beats over a valid/ready stream. When the last beat has been taken downstream, it raises a one-cycle completion strobe, which frees the processor to issue its next write.

A read request carries only the aligned address. It becomes a single header beat with every byte enable cleared. Read data coming back from downstream is handed to the processor as the whole 32-byte block, with no byte dropped, because the processor may have folded several reads into one request. Only one access is held at a time, and a new request waits until the current packet has fully left.

Top module: `dspkt_builder`

## Requirements
- R1: Header beat layout: bits [39:0] hold the request address with bits [4:0] forced to zero, and bit [127] is 1 for a write and 0 for a read. Bits [126:72] are zero.
- R2: Header bits [40+4i+3:40+4i] all equal mask bit i, for i = 0..7. For a read the whole enable field [71:40] is zero.
- R3: A write produces three beats: the header, then data beat 0 carrying block bytes 0..15 (byte 0 in bits [7:0]), then data beat 1 carrying bytes 16..31. pktLast is 1 only on data beat 1.
- R4: A read produces only the header beat, with pktLast set on it.
- R5: wrDone is high for exactly one cycle per write: the cycle in which the last data beat is accepted (pktValid, pktReady and pktLast all high). It is never high for a read.
- R6: reqReady is high only when no packet is pending. A request is accepted on a clock edge where reqValid and reqReady are both high. From then until the final beat has been accepted, reqReady stays low, and pktValid stays high.
- R7: While pktValid is high and pktReady is low, pktValid and pktData hold their values into the next cycle.
- R8: addrErr is high for one cycle, in the cycle after a request is accepted whose address bits [4:0] are not all zero. It is low otherwise.
- R9: retValid and retData repeat rspValid and the full 256-bit rspData one cycle later, without modification.
- R10: While reset is high, and in the first cycle after it is released, pktValid, wrDone, addrErr and retValid are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 40 | Request address |
| reqMask | input | 8 | One enable per 4-byte slice (writes) |
| reqData | input | 256 | Write data block |
| pktValid | output | 1 | Packet beat present |
| pktReady | input | 1 | Downstream takes the beat |
| pktData | output | 128 | Packet beat |
| pktLast | output | 1 | Final beat of the packet |
| wrDone | output | 1 | Completion strobe for a write |
| addrErr | output | 1 | Misaligned request seen |
| rspValid | input | 1 | Read data from downstream valid |
| rspData | input | 256 | Read data from downstream |
| retValid | output | 1 | Read data to processor valid |
| retData | output | 256 | Read data to processor, all 32 bytes |

## Verification
On every cycle, the assertions check the stream hold rule under backpressure. They also check that completion only appears with an accepted last beat, that no request is taken while a beat is pending, that each new packet opens with an aligned address, that the error flag follows an acceptance, and that the return path follows its input. The bench alone can show the contents of each beat: the enable expansion for particular masks, the read-versus-write packet shapes, and the data slicing. It can also show that back-to-back writes are really serialised, and the exact cycle in which reqReady reopens.

// File: rtl/dspkt_pkg.sv
package dspkt_pkg;
  localparam int ADDR_W      = 40;
  localparam int BLOCK_BYTES = 32;
  localparam int BEAT_BYTES  = 16;
  localparam int MASK_GRAN   = 4;

  localparam int BLOCK_W = BLOCK_BYTES * 8;
  localparam int BEAT_W  = BEAT_BYTES * 8;
  localparam int BEATS   = BLOCK_BYTES / BEAT_BYTES;
  localparam int MASK_W  = BLOCK_BYTES / MASK_GRAN;
  localparam int IDX_W   = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int BE_LSB  = ADDR_W;

  typedef struct packed {
    logic             load;
    logic             hdrSel;
    logic [IDX_W-1:0] beatIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/dspkt_ctrl.sv
module dspkt_ctrl
  import dspkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  input  logic        pktReady,
  output logic        pktValid,
  output logic        pktLast,
  output logic        wrDone,
  output ctlStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} state_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  state_t           state;
  logic [IDX_W-1:0] beat;
  logic             isWr;
  logic             lastData;

  assign lastData = (state == ST_DATA) && (beat == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      beat  <= '0;
      isWr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_HDR;
          isWr  <= reqWrite;
          beat  <= '0;
        end
        ST_HDR: if (pktReady) begin
          state <= isWr ? ST_DATA : ST_IDLE;
        end
        ST_DATA: if (pktReady) begin
          if (beat == LAST_IDX) state <= ST_IDLE;
          else                  beat  <= beat + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady        = (state == ST_IDLE);
    pktValid        = (state != ST_IDLE);
    pktLast         = ((state == ST_HDR) && !isWr) || lastData;
    wrDone          = lastData && pktReady;
    strobes.load    = reqValid && (state == ST_IDLE);
    strobes.hdrSel  = (state == ST_HDR);
    strobes.beatIdx = beat;
  end
endmodule

// File: rtl/dspkt_datapath.sv
module dspkt_datapath
  import dspkt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobes_t        strobes,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [MASK_W-1:0]  reqMask,
  input  logic [BLOCK_W-1:0] reqData,
  output logic [BEAT_W-1:0]  pktData,
  output logic               addrErr,
  input  logic               rspValid,
  input  logic [BLOCK_W-1:0] rspData,
  output logic               retValid,
  output logic [BLOCK_W-1:0] retData
);
  logic [BLOCK_BYTES-1:0] expBe;
  logic [BLOCK_BYTES-1:0] beQ;
  logic [ADDR_W-1:0]      addrQ;
  logic [BLOCK_W-1:0]     dataQ;
  logic                   wrQ;
  logic [BEAT_W-1:0]      header;

  for (genvar i = 0; i < MASK_W; i++) begin : g_expand
    assign expBe[i*MASK_GRAN +: MASK_GRAN] = {MASK_GRAN{reqMask[i]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      dataQ   <= '0;
      beQ     <= '0;
      wrQ     <= 1'b0;
      addrErr <= 1'b0;
    end else begin
      addrErr <= strobes.load && (|reqAddr[OFF_W-1:0]);
      if (strobes.load) begin
        addrQ <= {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        dataQ <= reqWrite ? reqData : '0;
        beQ   <= reqWrite ? expBe : '0;
        wrQ   <= reqWrite;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      retValid <= 1'b0;
      retData  <= '0;
    end else begin
      retValid <= rspValid;
      retData  <= rspData;
    end
  end

  always_comb begin
    header                           = '0;
    header[ADDR_W-1:0]               = addrQ;
    header[BE_LSB +: BLOCK_BYTES]    = beQ;
    header[BEAT_W-1]                 = wrQ;
    pktData = strobes.hdrSel ? header : dataQ[strobes.beatIdx*BEAT_W +: BEAT_W];
  end
endmodule

// File: rtl/dspkt_builder.sv
module dspkt_builder
  import dspkt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [MASK_W-1:0]  reqMask,
  input  logic [BLOCK_W-1:0] reqData,
  output logic               pktValid,
  input  logic               pktReady,
  output logic [BEAT_W-1:0]  pktData,
  output logic               pktLast,
  output logic               wrDone,
  output logic               addrErr,
  input  logic               rspValid,
  input  logic [BLOCK_W-1:0] rspData,
  output logic               retValid,
  output logic [BLOCK_W-1:0] retData
);
  ctlStrobes_t strobes;

  dspkt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .pktReady (pktReady),
    .pktValid (pktValid),
    .pktLast  (pktLast),
    .wrDone   (wrDone),
    .strobes  (strobes)
  );

  dspkt_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqMask  (reqMask),
    .reqData  (reqData),
    .pktData  (pktData),
    .addrErr  (addrErr),
    .rspValid (rspValid),
    .rspData  (rspData),
    .retValid (retValid),
    .retData  (retData)
  );
endmodule

// File: rtl/dspkt_builder_chk.sv
module dspkt_builder_chk
  import dspkt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic               reqReady,
  input logic               pktValid,
  input logic               pktReady,
  input logic [BEAT_W-1:0]  pktData,
  input logic               pktLast,
  input logic               wrDone,
  input logic               addrErr,
  input logic               rspValid,
  input logic [BLOCK_W-1:0] rspData,
  input logic               retValid,
  input logic [BLOCK_W-1:0] retData
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    pktValid && !pktReady |=> pktValid && $stable(pktData)); // R7
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
    wrDone |-> pktValid && pktReady && pktLast); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    pktValid |-> !reqReady); // R6
  AST_HDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(pktValid) |-> pktData[OFF_W-1:0] == '0); // R1
  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    addrErr |-> $past(reqValid && reqReady)); // R8
  AST_RET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> retValid && retData == $past(rspData)); // R9
endmodule

bind dspkt_builder dspkt_builder_chk u_chk (.*);

// File: tb/dspkt_builder_bench.sv
module dspkt_builder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [39:0]  reqAddr = '0;
  logic [7:0]   reqMask = '0;
  logic [255:0] reqData = '0;
  logic         pktReady = 1'b1, rspValid = 1'b0;
  logic [255:0] rspData = '0;
  logic         reqReady, pktValid, pktLast, wrDone, addrErr, retValid;
  logic [127:0] pktData;
  logic [255:0] retData;

  int vectors = 0, misses = 0, cycles = 0, readyMode = 0;
  bit running = 1'b0;

  typedef struct { logic [127:0] d; bit last; bit done; string tag; } beat_t;
  beat_t q[$];
  bit           errExp = 1'b0, prevRspV = 1'b0;
  logic [255:0] prevRspD = '0;

  dspkt_builder u_dspkt_builder (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: compare at the falling edge, then step.
  always @(negedge clk) begin
    if (running) begin
      bit acc;
      chk("R6 reqReady", 256'(reqReady), 256'(q.size() == 0));
      chk("R6 pktValid", 256'(pktValid), 256'(q.size() != 0));
      if (q.size() != 0) begin
        chk(q[0].tag, 256'(pktData), 256'(q[0].d));
        chk("R3 R4 pktLast", 256'(pktLast), 256'(q[0].last));
        chk("R5 wrDone", 256'(wrDone), 256'(pktReady && q[0].done));
      end else chk("R5 wrDone idle", 256'(wrDone), 256'(0));
      chk("R8 addrErr", 256'(addrErr), 256'(errExp));
      chk("R9 retValid", 256'(retValid), 256'(prevRspV));
      if (prevRspV) chk("R9 retData", retData, prevRspD);
      acc    = reqValid && (q.size() == 0);
      errExp = acc && (reqAddr[4:0] != 5'd0);
      if (pktValid && pktReady && q.size() != 0) void'(q.pop_front());
      if (acc) begin
        beat_t h;
        logic [31:0] be;
        be = '0;
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 4; j++) be[i*4+j] = reqWrite & reqMask[i];
        h.d = '0;
        h.d[39:0]  = {reqAddr[39:5], 5'd0};
        h.d[71:40] = be;
        h.d[127]   = reqWrite;
        h.last = !reqWrite; h.done = 1'b0; h.tag = "R1 R2 header (R7 on stall)";
        q.push_back(h);
        if (reqWrite) begin
          for (int k = 0; k < 2; k++) begin
            beat_t b;
            b.d = reqData[k*128 +: 128];
            b.last = (k == 1); b.done = (k == 1); b.tag = "R3 data beat (R7 on stall)";
            q.push_back(b);
          end
        end
      end
      prevRspV = rspValid;
      prevRspD = rspData;
    end
  end

  // Downstream ready pattern
  always @(posedge clk) begin
    #1;
    case (readyMode)
      0: pktReady = 1'b1;
      1: pktReady = cycles[0];
      2: pktReady = (cycles % 4) == 3;
      default: pktReady = 1'b0;
    endcase
  end

  // Return path stimulus
  always @(posedge clk) begin
    #1;
    rspValid = running && ($urandom % 3 == 0);
    rspData  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic send(bit wr, logic [39:0] a, logic [7:0] m);
    bit taken = 1'b0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqMask = m;
    reqData = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    while (!taken) begin
      @(negedge clk);
      taken = reqReady;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 pktValid", 256'(pktValid), 256'(0));
    chk("R10 reqReady", 256'(reqReady), 256'(1));
    chk("R10 wrDone", 256'(wrDone), 256'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after release pktValid", 256'(pktValid), 256'(0));
    chk("R10 after release addrErr", 256'(addrErr), 256'(0));
    chk("R10 after release retValid", 256'(retValid), 256'(0));
    @(posedge clk); #1;
    running = 1'b1;
    readyMode = 0;
    send(1'b1, 40'h12_3456_7800, 8'hFF);   // R2 full mask
    send(1'b1, 40'h00_0000_0040, 8'hA5);   // R2 mixed mask, back-to-back R6
    send(1'b1, 40'hFF_FFFF_FFE0, 8'h00);   // R2 empty mask
    send(1'b0, 40'h00_1000_0020, 8'hFF);   // R4 read, mask ignored
    drain();
    send(1'b1, 40'h00_0000_0113, 8'h01);   // R8 misaligned write
    send(1'b0, 40'h00_0000_0007, 8'h00);   // R8 misaligned read
    drain();
    readyMode = 1;                           // R7 alternating stall
    send(1'b1, 40'h0A_0000_0000, 8'h3C);
    send(1'b0, 40'h0B_0000_0060, 8'h00);
    send(1'b1, 40'h0C_0000_00A0, 8'h81);
    drain();
    readyMode = 2;                           // R6 R7 long stalls
    send(1'b1, 40'h55_5555_5540, 8'h5A);
    send(1'b1, 40'h2A_AAAA_AAA0, 8'hC3);
    send(1'b0, 40'h01_0203_0400, 8'h00);
    drain();
    readyMode = 0;
    for (int n = 0; n < 20; n++) begin
      bit w = n[0] | n[2];
      send(w, {$urandom, $urandom} & 40'hFF_FFFF_FFFF, 8'($urandom));
    end
    drain();
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule